// File: doc/BRIEF.md
# Floppy Flux Sample Capture Engine

This block records the raw magnetic read stream of a floppy drive into an external 128K x 8 static RAM. It does not decode any data. The drive's read-pulse line drives a toggle stage, which turns every flux pulse into a level change. A pulse that is narrower than the sample period is therefore still recorded. The resulting level, and the index-hole line, are sampled on a divided tick and packed into bytes. Each finished byte is written to the RAM at an address taken from an internal self-incrementing counter, so no controller has to drive an address bus.

A controller clears the address counter while the block is idle and then arms the block. Capture starts on the next falling edge of the index line. It ends on the following falling edge of the index line, or when the counter runs past the top of the memory, whichever comes first. Afterwards the RAM holds the track image. Data bits and index bits alternate in it, so every position in the track can be related to the index hole.

Top module: `flux_capture`

## Requirements
- R1: After reset, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are high, `busy` and `done` are low, and `sram_addr` is 0.
- R2: A one-cycle `arm` pulse in the idle or finished state raises `busy`. While armed, no RAM write occurs until a falling edge appears on `index_n`.
- R3: Each falling edge of `rd_pulse_n` inverts the recorded data level, which is 0 after reset and is kept from one capture to the next.
- R4: Sample ticks alternate, starting with a data sample; odd-numbered ticks take the index level (1 = `index_n` low). Each byte holds 8 ticks, and the first tick lands in bit 7. Data samples therefore sit in bits 7, 5, 3 and 1, and index samples in bits 6, 4, 2 and 0.
- R5: Each completed byte is written at the current counter address, and the counter then advances by one. Successive captures continue from where the previous one left the counter.
- R6: For each write, `sram_we_n` is low for exactly one clock. `sram_ce_n` is low, and address and data are held constant, from one clock before the strobe until one clock after it.
- R7: A second falling edge of `index_n` during capture stops sampling. A partly filled byte is discarded, and the block then drops `busy` and raises `done`.
- R8: After the byte at the highest address is written, the counter wraps to 0 and the capture ends with `done` high.
- R9: `clr` sets the counter to 0 when the block is not busy, and is ignored while it is busy.
- R10: `sram_oe_n` is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; sample ticks are derived from it |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_pulse_n | input | 1 | Raw read pulses from the drive, active low |
| index_n | input | 1 | Index-hole signal from the drive, active low |
| arm | input | 1 | Arm capture to start at the next index edge |
| clr | input | 1 | Clear the address counter (idle only) |
| busy | output | 1 | High while armed, capturing or draining the last write |
| done | output | 1 | High once a capture has finished, until re-armed |
| sram_addr | output | ADDR_W (17) | RAM address, from the internal counter |
| sram_dq | output | 8 | RAM write data |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM read strobe, active low, held inactive |

## Verification
The strobe assertions assume the sample divider gives at least eight clocks per byte, so that a write sequence always finishes before the next byte is ready. The address-step property assumes `clr` never reaches the counter while a write is in flight, which the block's own gating guarantees. The stimulus keeps every drive-line change several clocks away from a sample tick. Read pulses are one clock wide and spaced a full sample period apart, and the index line is only pulled low at the start and stop points, so each expected bit is unambiguous.

// File: rtl/flux_pkg.sv
// Shared types for the flux capture engine.
package flux_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        CAP_IDLE,
        CAP_ARMED,
        CAP_RUN,
        CAP_DRAIN,
        CAP_DONE
    } cap_state_t;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_SETUP,
        WR_STROBE,
        WR_HOLD
    } wr_phase_t;
endpackage

// File: rtl/flux_front.sv
// Drive-line front end: synchronizes the read-pulse and index lines, finds
// their falling edges and toggles the NRZ level on every read pulse.
// Assumes pulses are at least one clock wide and at least two clocks apart.
module flux_front #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_pulse_n,
    input  logic index_n,
    output logic nrz,
    output logic idx_act,
    output logic idx_fall
);
    localparam int unsigned N_LINES = 2;

    logic [N_LINES-1:0] raw;
    logic [N_LINES-1:0] lvl;
    logic [N_LINES-1:0] fall;

    assign raw = {index_n, rd_pulse_n};

    genvar g;
    generate
        for (g = 0; g < N_LINES; g++) begin : g_line
            logic [SYNC_STAGES-1:0] chain;
            logic                   prv;
            // Synchronizer chain plus previous-level register; idle level is high.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain <= '1;
                    prv   <= 1'b1;
                end else begin
                    chain <= {chain[SYNC_STAGES-2:0], raw[g]};
                    prv   <= chain[SYNC_STAGES-1];
                end
            end
            assign lvl[g]  = chain[SYNC_STAGES-1];
            assign fall[g] = prv & ~chain[SYNC_STAGES-1];
        end
    endgenerate

    // Toggle stage: one level change per read pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) nrz <= 1'b0;
        else if (fall[0]) nrz <= ~nrz;
    end

    assign idx_act  = ~lvl[1];
    assign idx_fall = fall[1];
endmodule

// File: rtl/flux_packer.sv
// Sample-tick generator and serial-to-byte shifter. Even ticks take the
// NRZ level, odd ticks the index level; eight ticks make one byte.
// Assumes restart is a single-cycle pulse at capture start.
module flux_packer #(
    parameter int unsigned SAMPLE_DIV = 20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       restart,
    input  logic                       run,
    input  logic                       nrz,
    input  logic                       idx_act,
    output logic                       byte_vld,
    output logic [flux_pkg::BYTE_W-1:0] byte_out
);
    localparam int unsigned DIV_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
    localparam int unsigned BIT_W = $clog2(flux_pkg::BYTE_W);

    logic [DIV_W-1:0]            div;
    logic [BIT_W-1:0]            nbit;
    logic [flux_pkg::BYTE_W-1:0] sr;
    logic [flux_pkg::BYTE_W-1:0] sr_nxt;
    logic                        tick;
    logic                        last_bit;

    assign tick     = run && (div == DIV_W'(SAMPLE_DIV - 1));
    assign last_bit = (nbit == BIT_W'(flux_pkg::BYTE_W - 1));
    assign sr_nxt   = {sr[flux_pkg::BYTE_W-2:0], nbit[0] ? idx_act : nrz};

    // Divider, bit counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            div  <= '0;
            nbit <= '0;
            sr   <= '0;
        end else if (run) begin
            div <= tick ? '0 : div + 1'b1;
            if (tick) begin
                sr   <= sr_nxt;
                nbit <= nbit + 1'b1;
            end
        end
    end

    // Hand a completed byte to the writer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_vld <= 1'b0;
            byte_out <= '0;
        end else begin
            byte_vld <= tick && last_bit;
            if (tick && last_bit) byte_out <= sr_nxt;
        end
    end
endmodule

// File: rtl/flux_sram_wr.sv
// RAM write sequencer and address counter. A write is setup, strobe and
// hold, one clock each; the address advances at the end of hold.
// Assumes bytes arrive at least four clocks apart.
module flux_sram_wr #(
    parameter int unsigned ADDR_W = 17
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        byte_vld,
    input  logic [flux_pkg::BYTE_W-1:0] byte_in,
    input  logic                        clr_addr,
    output logic [ADDR_W-1:0]           sram_addr,
    output logic [flux_pkg::BYTE_W-1:0] sram_dq,
    output logic                        sram_ce_n,
    output logic                        sram_we_n,
    output logic                        wr_busy,
    output logic                        wrap
);
    import flux_pkg::*;

    wr_phase_t phase;

    // Phase sequencer and data latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= WR_IDLE;
            sram_dq <= '0;
        end else begin
            unique case (phase)
                WR_IDLE: if (byte_vld) begin
                    phase   <= WR_SETUP;
                    sram_dq <= byte_in;
                end
                WR_SETUP:  phase <= WR_STROBE;
                WR_STROBE: phase <= WR_HOLD;
                WR_HOLD:   phase <= WR_IDLE;
                default:   phase <= WR_IDLE;
            endcase
        end
    end

    // Address counter: synchronous clear, step after each write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_addr) sram_addr <= '0;
        else if (phase == WR_HOLD) sram_addr <= sram_addr + 1'b1;
    end

    assign sram_ce_n = (phase == WR_IDLE);
    assign sram_we_n = (phase != WR_STROBE);
    assign wr_busy   = (phase != WR_IDLE);
    assign wrap      = (phase == WR_HOLD) && (&sram_addr);
endmodule

// File: rtl/flux_capture.sv
// Top of the flux capture engine: arming, start/stop on index edges and
// wiring of front end, packer and RAM writer. Assumes SAMPLE_DIV >= 1.
module flux_capture #(
    parameter int unsigned ADDR_W      = 17,
    parameter int unsigned SAMPLE_DIV  = 20,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_pulse_n,
    input  logic              index_n,
    input  logic              arm,
    input  logic              clr,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [7:0]        sram_dq,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n
);
    import flux_pkg::*;

    cap_state_t        state;
    cap_state_t        state_nxt;
    logic              nrz;
    logic              idx_act;
    logic              idx_fall;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_data;
    logic              wr_busy;
    logic              wrap;
    logic              restart;
    logic              clr_ok;

    flux_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_pulse_n (rd_pulse_n),
        .index_n    (index_n),
        .nrz        (nrz),
        .idx_act    (idx_act),
        .idx_fall   (idx_fall)
    );

    flux_packer #(.SAMPLE_DIV(SAMPLE_DIV)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .run      (state == CAP_RUN),
        .nrz      (nrz),
        .idx_act  (idx_act),
        .byte_vld (byte_vld),
        .byte_out (byte_data)
    );

    flux_sram_wr #(.ADDR_W(ADDR_W)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .byte_in   (byte_data),
        .clr_addr  (clr_ok),
        .sram_addr (sram_addr),
        .sram_dq   (sram_dq),
        .sram_ce_n (sram_ce_n),
        .sram_we_n (sram_we_n),
        .wr_busy   (wr_busy),
        .wrap      (wrap)
    );

    // Next-state decode of the capture controller.
    always_comb begin
        state_nxt = state;
        unique case (state)
            CAP_IDLE, CAP_DONE: if (arm) state_nxt = CAP_ARMED;
            CAP_ARMED:          if (idx_fall) state_nxt = CAP_RUN;
            CAP_RUN: begin
                if (wrap) state_nxt = CAP_DONE;
                else if (idx_fall) state_nxt = CAP_DRAIN;
            end
            CAP_DRAIN: begin
                if (wrap || (!wr_busy && !byte_vld)) state_nxt = CAP_DONE;
            end
            default: state_nxt = CAP_IDLE;
        endcase
    end

    // Capture state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CAP_IDLE;
        else state <= state_nxt;
    end

    assign restart   = (state == CAP_ARMED) && idx_fall;
    assign busy      = (state == CAP_ARMED) || (state == CAP_RUN) || (state == CAP_DRAIN);
    assign done      = (state == CAP_DONE);
    assign clr_ok    = clr && !busy;
    assign sram_oe_n = 1'b1;
endmodule

// File: rtl/flux_capture_chk.sv
// Property checker for flux_capture, attached by bind.
module flux_capture_chk #(
    parameter int unsigned ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [7:0]        sram_dq,
    input logic              sram_ce_n,
    input logic              sram_we_n
);
    a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |=> sram_we_n);

    a_r6_setup_before: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> ($past(!sram_ce_n) && $stable(sram_addr) && $stable(sram_dq)));

    a_r6_hold_after: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (!sram_ce_n && $stable(sram_addr) && $stable(sram_dq)));

    a_r6_select_covers: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !sram_ce_n);

    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |=> (sram_addr == ADDR_W'($past(sram_addr) + 1'b1)));

    a_r2_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_ce_n |-> busy);

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
endmodule

bind flux_capture flux_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .sram_addr (sram_addr),
    .sram_dq   (sram_dq),
    .sram_ce_n (sram_ce_n),
    .sram_we_n (sram_we_n)
);

// File: tb/flux_capture_test.sv
// Scoreboard bench: the driver predicts each RAM write, the monitor compares.
module flux_capture_test;
    localparam int AW  = 5;
    localparam int DIV = 8;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [7:0]    d;
    } wr_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_pulse_n = 1'b1;
    logic          index_n = 1'b1;
    logic          arm = 1'b0;
    logic          clr = 1'b0;
    logic          busy, done, sram_ce_n, sram_we_n, sram_oe_n;
    logic [AW-1:0] sram_addr;
    logic [7:0]    sram_dq;

    int  n_cmp = 0;
    int  n_bad = 0;
    int  n_seen = 0;
    int  n_pushed = 0;
    wr_t exp_q[$];
    logic          nrz_m = 1'b0;
    logic [AW-1:0] addr_m = '0;
    logic          we_prev = 1'b1;

    flux_capture #(.ADDR_W(AW), .SAMPLE_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .rd_pulse_n(rd_pulse_n), .index_n(index_n),
        .arm(arm), .clr(clr), .busy(busy), .done(done), .sram_addr(sram_addr),
        .sram_dq(sram_dq), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compare every write strobe with the predicted item.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!we_prev) chk("R6 strobe one clock", sram_we_n, 1'b1);
            if (sram_we_n === 1'b0) begin
                n_seen++;
                chk("R6 select during strobe", sram_ce_n, 1'b0);
                chk("R10 read strobe idle", sram_oe_n, 1'b1);
                if (exp_q.size() == 0) begin
                    chk("R5 unexpected write", {sram_addr, sram_dq}, 32'hFFFF_FFFF);
                end else begin
                    wr_t e;
                    e = exp_q.pop_front();
                    chk("R5 write address", sram_addr, e.a);
                    chk("R3 R4 write data", sram_dq, e.d);
                end
            end
            we_prev = sram_we_n;
        end
    end

    function automatic bit toggle_at(input int pat, input int k);
        case (pat)
            0:       return (k % 3) == 0;
            1:       return (k % 2) == 1;
            default: return ((k * 7) % 5) == 0;
        endcase
    endfunction

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    // Driver: index start edge, then one stimulus slot per sample tick.
    task automatic capture(input int nbytes, input int partial, input bit stop, input int pat);
        logic [7:0] b;
        int total;
        b = '0;
        total = nbytes * 8 + partial;
        @(negedge clk); index_n = 1'b0;
        for (int k = 0; k < total; k++) begin
            bit tog, ia, bv;
            if (k == 0) begin
                repeat (6) @(negedge clk);
            end else begin
                @(negedge clk); rd_pulse_n = 1'b1;
                repeat (7) @(negedge clk);
            end
            tog = toggle_at(pat, k);
            ia  = (k < 4);
            rd_pulse_n = tog ? 1'b0 : 1'b1;
            index_n    = ia ? 1'b0 : 1'b1;
            if (tog) nrz_m = ~nrz_m;
            bv = (k % 2 == 0) ? nrz_m : ia;
            b  = {b[6:0], bv};
            if ((k % 8 == 7) && (k < nbytes * 8)) begin
                exp_q.push_back('{a: addr_m, d: b});
                n_pushed++;
                addr_m = addr_m + 1'b1;
            end
        end
        @(negedge clk); rd_pulse_n = 1'b1;
        if (stop) begin
            repeat (6) @(negedge clk);
            index_n = 1'b0;
        end
        repeat (40) @(negedge clk);
        index_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ce_n", sram_ce_n, 1'b1);
        chk("R1 we_n", sram_we_n, 1'b1);
        chk("R1 oe_n", sram_oe_n, 1'b1);
        chk("R1 busy", busy, 1'b0);
        chk("R1 done", done, 1'b0);
        chk("R1 addr", sram_addr, '0);

        // R2 arming waits for the index edge
        pulse(arm);
        repeat (2) @(negedge clk);
        chk("R2 busy after arm", busy, 1'b1);
        repeat (100) @(negedge clk);
        chk("R2 no write while armed", n_seen, 0);

        // Run A: three bytes, stop with three partial bits (R3 R4 R7)
        capture(3, 3, 1'b1, 0);
        chk("R7 done after stop", done, 1'b1);
        chk("R7 busy after stop", busy, 1'b0);
        chk("R7 partial byte dropped", n_seen, n_pushed);
        chk("R5 counter after run A", sram_addr, 3);

        // R9: clear ignored while armed; run B continues the address
        pulse(arm);
        repeat (2) @(negedge clk);
        pulse(clr);
        @(negedge clk);
        chk("R9 clear ignored while busy", sram_addr, 3);
        capture(2, 0, 1'b1, 1);
        chk("R5 counter after run B", sram_addr, 5);
        chk("R7 done after run B", done, 1'b1);

        // R9: clear accepted while idle
        pulse(clr);
        @(negedge clk);
        chk("R9 clear when idle", sram_addr, 0);
        addr_m = '0;

        // Run C: fill the whole space, wrap ends the capture (R8)
        pulse(arm);
        repeat (2) @(negedge clk);
        capture(1 << AW, 0, 1'b0, 2);
        chk("R8 done after wrap", done, 1'b1);
        chk("R8 busy after wrap", busy, 1'b0);
        chk("R8 address wrapped", sram_addr, 0);
        chk("R8 select released", sram_ce_n, 1'b1);
        chk("R5 all writes seen", n_seen, n_pushed);
        chk("R5 queue drained", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule